// File: doc/BRIEF.md
# Coprocessor Bus Data Transfer Sequencer

This block runs the data phase of a coprocessor load or store once the coprocessor has finished its busy phase. It also runs the single-word register transfer, in which the host uses the shared data bus with no memory access. A start pulse latches the decoded instruction fields: the direction bit, a word-count field, a register-file base index and a flag that marks a register transfer. The sequencer then moves one word in every main clock cycle in which the bus is granted to it.

The coprocessor decides the burst length, not the host. The count field is clamped to between 1 and 16 words, which bounds the time the host cannot take an interrupt. During the final word both handshake outputs go high, so the host stops stepping its address after that word. On a store the block supplies register-file words to the bus, through a data output and a separate output enable. On a load it writes the words it receives on the bus into its register file.

Top module: `cpx_xfer_seq`

## Requirements
- R1: After reset the block is idle: hsA and hsB are low, busOe is low and rfWe is low.
- R2: In a load (isLoad=1 at start), each cycle that moves a word asserts rfWe with rfWdata equal to busIn. The write address is baseReg plus the word index, starting at 0 and wrapping modulo 16.
- R3: In a store (isLoad=0 at start), busOe is high only in a cycle that moves a word. busOut then carries the register-file word read at baseReg plus the word index, modulo 16.
- R4: The burst length is taken from the 5-bit countField. A value of 0 gives 1 word, values 1 to 16 give that many words, and values 17 to 31 give 16 words.
- R5: hsA and hsB are both high in every cycle of the final word of a transfer, including held cycles, and both are low during every earlier word.
- R6: In a memory transfer, a cycle with busEn low moves no word. busOe and rfWe stay low, and the same word index is used when busEn returns.
- R7: In the cycle after the final word moves, the block is idle again with hsA and hsB low, and it accepts a new start.
- R8: A register transfer (isReg=1 at start) moves exactly one word, whatever countField holds. The word moves only in a cycle where memReqN, seqInd and busEn are all high, and the handshake outputs stay high until it has moved.
- R9: A start pulse that arrives while a transfer is in progress is ignored. The running transfer keeps its length, base and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startXfer | input | 1 | Pulse: the coprocessor has left busy, so latch the fields and begin |
| isLoad | input | 1 | Direction bit: 1 load into the coprocessor, 0 store from it |
| isReg | input | 1 | 1 selects a single-word register transfer |
| countField | input | 5 | Requested word count before clamping |
| baseReg | input | 4 | First register-file index |
| busEn | input | 1 | Bus grant; the block may use the bus only while high |
| memReqN | input | 1 | Host memory-request indicator, active low |
| seqInd | input | 1 | Host sequential indicator |
| busIn | input | 32 | Data bus as received |
| busOut | output | 32 | Data to drive onto the bus |
| busOe | output | 1 | Output enable for busOut |
| hsA | output | 1 | Handshake line A, high on the final word |
| hsB | output | 1 | Handshake line B, high on the final word |
| rfAddr | output | 4 | Register-file index for read and write |
| rfWe | output | 1 | Register-file write strobe |
| rfWdata | output | 32 | Register-file write data |
| rfRdata | input | 32 | Register-file read data at rfAddr |

## Verification
A wrong remaining-word count shows at hsA/hsB on the first word that it touches. If the count is too high, the handshake stays low on the intended last word. If it is too low, the handshake rises one or more words early and the block goes idle while the host still expects data. A stale or skipped word index shows as a wrong rfAddr on the very next moved word, and on a store also as a wrong busOut. Wrong gating of busEn, or of the register-cycle indicators, shows at busOe or rfWe in the same cycle.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } cpxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch base index, clear word index
    logic advance;  // a word moved this cycle
    logic write;    // load word into register file
    logic drive;    // put register-file word on the bus
  } cpxStrobe_t;

endpackage

// File: rtl/cpx_ctrl.sv
module cpx_ctrl
  import cpx_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int MAX_WORDS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startXfer,
  input  logic             isLoad,
  input  logic             isReg,
  input  logic [CNT_W-1:0] countField,
  input  logic             busEn,
  input  logic             memReqN,
  input  logic             seqInd,
  output cpxStrobe_t       strobe,
  output logic             lastWord
);

  localparam int REM_W = $clog2(MAX_WORDS + 1);

  cpxState_t        stateQ;
  logic [REM_W-1:0] remainQ;
  logic             loadQ;
  logic             regQ;
  logic             grantOk;
  logic             moveNow;

  function automatic logic [REM_W-1:0] clampCount(input logic [CNT_W-1:0] f);
    int v;
    v = int'(f);
    if (v == 0)              return REM_W'(1);
    else if (v > MAX_WORDS)  return REM_W'(MAX_WORDS);
    else                     return REM_W'(v);
  endfunction

  always_comb begin
    grantOk  = busEn && (!regQ || (memReqN && seqInd));
    moveNow  = (stateQ == ST_XFER) && grantOk;
    lastWord = (stateQ == ST_XFER) && (remainQ == REM_W'(1));
    strobe.capture = (stateQ == ST_IDLE) && startXfer;
    strobe.advance = moveNow;
    strobe.write   = moveNow && loadQ;
    strobe.drive   = moveNow && !loadQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      remainQ <= '0;
      loadQ   <= 1'b0;
      regQ    <= 1'b0;
    end else if (strobe.capture) begin
      stateQ  <= ST_XFER;
      remainQ <= isReg ? REM_W'(1) : clampCount(countField);
      loadQ   <= isLoad;
      regQ    <= isReg;
    end else if (moveNow) begin
      remainQ <= remainQ - REM_W'(1);
      if (lastWord) stateQ <= ST_IDLE;
    end
  end

endmodule

// File: rtl/cpx_dpath.sv
module cpx_dpath
  import cpx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RF_AW  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cpxStrobe_t        strobe,
  input  logic [RF_AW-1:0]  baseReg,
  input  logic [DATA_W-1:0] busIn,
  input  logic [DATA_W-1:0] rfRdata,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [RF_AW-1:0]  rfAddr,
  output logic              rfWe,
  output logic [DATA_W-1:0] rfWdata
);

  logic [RF_AW-1:0] baseQ;
  logic [RF_AW-1:0] idxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      idxQ  <= '0;
    end else if (strobe.capture) begin
      baseQ <= baseReg;
      idxQ  <= '0;
    end else if (strobe.advance) begin
      idxQ  <= idxQ + RF_AW'(1);
    end
  end

  always_comb begin
    rfAddr  = baseQ + idxQ;
    rfWe    = strobe.write;
    rfWdata = busIn;
    busOe   = strobe.drive;
    busOut  = strobe.drive ? rfRdata : '0;
  end

endmodule

// File: rtl/cpx_xfer_seq.sv
module cpx_xfer_seq
  import cpx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int RF_AW     = 4,
  parameter int CNT_W     = 5,
  parameter int MAX_WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startXfer,
  input  logic              isLoad,
  input  logic              isReg,
  input  logic [CNT_W-1:0]  countField,
  input  logic [RF_AW-1:0]  baseReg,
  input  logic              busEn,
  input  logic              memReqN,
  input  logic              seqInd,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic              hsA,
  output logic              hsB,
  output logic [RF_AW-1:0]  rfAddr,
  output logic              rfWe,
  output logic [DATA_W-1:0] rfWdata,
  input  logic [DATA_W-1:0] rfRdata
);

  cpxStrobe_t strobe;
  logic       lastWord;

  cpx_ctrl #(.CNT_W(CNT_W), .MAX_WORDS(MAX_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startXfer(startXfer), .isLoad(isLoad),
    .isReg(isReg), .countField(countField), .busEn(busEn),
    .memReqN(memReqN), .seqInd(seqInd), .strobe(strobe), .lastWord(lastWord)
  );

  cpx_dpath #(.DATA_W(DATA_W), .RF_AW(RF_AW)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseReg(baseReg),
    .busIn(busIn), .rfRdata(rfRdata), .busOut(busOut), .busOe(busOe),
    .rfAddr(rfAddr), .rfWe(rfWe), .rfWdata(rfWdata)
  );

  assign hsA = lastWord;
  assign hsB = lastWord;

endmodule

// File: rtl/cpx_xfer_seq_chk.sv
module cpx_xfer_seq_chk #(
  parameter int MAX_WORDS = 16
) (
  input logic clk,
  input logic rstN,
  input logic busEn,
  input logic busOe,
  input logic rfWe,
  input logic hsA,
  input logic hsB
);

  localparam int CW = $clog2(MAX_WORDS + 1) + 1;

  logic [CW-1:0] wordCnt;
  logic          moved;

  assign moved = rfWe || busOe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                wordCnt <= '0;
    else if (moved && hsA)    wordCnt <= '0;
    else if (moved)           wordCnt <= wordCnt + CW'(1);
  end

  p_drive_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> busEn);

  p_write_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> (busEn && !busOe));

  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hsA && moved) |=> (!hsA && !hsB));

  p_hold_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hsA && !busEn) |=> (hsA && hsB));

  p_burst_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    moved |-> (wordCnt < CW'(MAX_WORDS)));

endmodule

bind cpx_xfer_seq cpx_xfer_seq_chk #(.MAX_WORDS(MAX_WORDS)) u_chk (
  .clk(clk), .rstN(rstN), .busEn(busEn), .busOe(busOe),
  .rfWe(rfWe), .hsA(hsA), .hsB(hsB)
);

// File: tb/tb_cpx_xfer_seq.sv
module tb_cpx_xfer_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startXfer = 1'b0;
  logic        isLoad = 1'b0;
  logic        isReg = 1'b0;
  logic [4:0]  countField = '0;
  logic [3:0]  baseReg = '0;
  logic        busEn = 1'b0;
  logic        memReqN = 1'b0;
  logic        seqInd = 1'b0;
  logic [31:0] busIn = '0;
  logic [31:0] busOut;
  logic        busOe;
  logic        hsA;
  logic        hsB;
  logic [3:0]  rfAddr;
  logic        rfWe;
  logic [31:0] rfWdata;
  logic [31:0] rfRdata;
  logic [31:0] mem [16];

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cpx_xfer_seq dut (
    .clk(clk), .rstN(rstN), .startXfer(startXfer), .isLoad(isLoad),
    .isReg(isReg), .countField(countField), .baseReg(baseReg),
    .busEn(busEn), .memReqN(memReqN), .seqInd(seqInd), .busIn(busIn),
    .busOut(busOut), .busOe(busOe), .hsA(hsA), .hsB(hsB), .rfAddr(rfAddr),
    .rfWe(rfWe), .rfWdata(rfWdata), .rfRdata(rfRdata)
  );

  assign rfRdata = mem[rfAddr];
  always @(posedge clk) if (rfWe) mem[rfAddr] <= rfWdata;

  // {load, field, base, expected words}
  localparam logic [14:0] VEC [0:7] = '{
    {1'b1, 5'd0,  4'd3,  5'd1},
    {1'b1, 5'd4,  4'd14, 5'd4},
    {1'b0, 5'd4,  4'd14, 5'd4},
    {1'b1, 5'd16, 4'd0,  5'd16},
    {1'b0, 5'd16, 4'd0,  5'd16},
    {1'b1, 5'd20, 4'd5,  5'd16},
    {1'b0, 5'd31, 4'd2,  5'd16},
    {1'b0, 5'd1,  4'd9,  5'd1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] pat(input int base, input int w);
    return {8'hC0, 4'(base), 4'h3, 8'(w), 8'h5A};
  endfunction

  task automatic doXfer(input bit load, input int field, input int base,
                        input int expW, input bit gap, input int restartAt);
    int w = 0;
    int cyc = 0;
    @(negedge clk);
    startXfer = 1; isLoad = load; isReg = 0; countField = 5'(field);
    baseReg = 4'(base); busEn = 0;
    @(negedge clk);
    startXfer = 0;
    while (w < expW && cyc < 100) begin
      busEn = gap ? cyc[0] : 1'b1;
      busIn = pat(base, w);
      if (cyc == restartAt) begin
        startXfer = 1; isLoad = ~load; countField = 5'd31; baseReg = 4'd8;
      end else begin
        startXfer = 0;
      end
      #1;
      check((hsA && hsB) == (w == expW - 1), "R5 handshake on last word only",
            {30'b0, hsB, hsA}, {31'b0, (w == expW - 1)});
      if (busEn) begin
        if (load) begin
          check(rfWe && !busOe && rfAddr == 4'(base + w) && rfWdata == pat(base, w),
                "R2 load write", {27'b0, rfWe, rfAddr}, {27'b1, 4'(base + w)});
        end else begin
          check(busOe && !rfWe && busOut == mem[4'(base + w)], "R3 store drive",
                busOut, mem[4'(base + w)]);
        end
        w++;
      end else begin
        check(!busOe && !rfWe, "R6 no move while busEn low",
              {30'b0, busOe, rfWe}, 32'd0);
      end
      @(negedge clk);
      cyc++;
    end
    startXfer = 0; busEn = 1; #1;
    check(w == expW, "R4 burst length", 32'(w), 32'(expW));
    check(!hsA && !hsB && !busOe && !rfWe, "R7 idle after last word",
          {29'b0, hsA, busOe, rfWe}, 32'd0);
    if (load) begin
      for (int i = 0; i < expW; i++)
        check(mem[4'(base + i)] == pat(base, i), "R2 loaded word",
              mem[4'(base + i)], pat(base, i));
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h1000_0000 + 32'(i * 32'h0101);
    repeat (3) @(negedge clk);
    #1;
    check(!hsA && !hsB && !busOe && !rfWe, "R1 reset state",
          {29'b0, hsA, busOe, rfWe}, 32'd0);
    rstN = 1;

    for (int v = 0; v < 8; v++)
      doXfer(VEC[v][14], int'(VEC[v][13:9]), int'(VEC[v][8:5]),
             int'(VEC[v][4:0]), 1'b0, -1);

    // held cycles, store then load
    doXfer(1'b0, 5, 7, 5, 1'b1, -1);   // R6
    doXfer(1'b1, 3, 11, 3, 1'b1, -1);  // R6
    // start while busy is ignored
    doXfer(1'b1, 3, 0, 3, 1'b0, 1);    // R9
    check(mem[8] != pat(0, 0), "R9 no write at ignored base", mem[8], pat(0, 0));

    // register transfer, load direction
    @(negedge clk);
    startXfer = 1; isReg = 1; isLoad = 1; countField = 5'd7; baseReg = 4'd6;
    @(negedge clk);
    startXfer = 0; busEn = 1; memReqN = 0; seqInd = 1; busIn = 32'hFEED_0001; #1;
    check(!rfWe && hsA && hsB, "R8 wait for bus-only cycle",
          {30'b0, rfWe, hsA}, 32'd1);
    @(negedge clk);
    memReqN = 1; seqInd = 0; #1;
    check(!rfWe && hsA && hsB, "R8 seqInd low blocks word",
          {30'b0, rfWe, hsA}, 32'd1);
    @(negedge clk);
    seqInd = 1; #1;
    check(rfWe && rfAddr == 4'd6 && hsA && hsB, "R8 register word moves",
          {27'b0, rfWe, rfAddr}, {27'b1, 4'd6});
    @(negedge clk); #1;
    check(!hsA && !hsB && !rfWe, "R8 single word then idle",
          {30'b0, hsA, rfWe}, 32'd0);
    check(mem[6] == 32'hFEED_0001, "R8 register word stored", mem[6], 32'hFEED_0001);

    // register transfer, store direction
    @(negedge clk);
    startXfer = 1; isReg = 1; isLoad = 0; countField = 5'd0; baseReg = 4'd6;
    memReqN = 0; seqInd = 0;
    @(negedge clk);
    startXfer = 0; busEn = 0; memReqN = 1; seqInd = 1; #1;
    check(!busOe && hsA, "R8 no drive without busEn", {30'b0, busOe, hsA}, 32'd1);
    @(negedge clk);
    busEn = 1; #1;
    check(busOe && busOut == 32'hFEED_0001, "R8 register store drive",
          busOut, 32'hFEED_0001);
    @(negedge clk); #1;
    check(!hsA && !busOe, "R8 store ends", {30'b0, hsA, busOe}, 32'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule